// File: doc/BRIEF.md
# RTC interrupt mask and status unit

This unit gathers the interrupt sources of a real-time clock, one alarm-match pulse and six periodic strobes (100 Hz, 10 Hz, second, minute, hour, day), into sticky status flags. It drives one active-low interrupt output. Each source is gated by its own mask bit, so only enabled sources can set a flag.

Software reaches the unit through a small address/data port that has a write enable and a read strobe. The mask register and the status register share one address. A write to that address loads the mask. A read from it returns the status byte, and that read also clears every flag on the next clock edge. Status bit 7 is a global indicator that stays set while any source flag is set. The interrupt output follows this indicator. The alarm flag and the periodic flags are independent of each other and can be pending together.

Top module: `rtc_irq_unit`

## Requirements
- R1: A write with `bus_addr` = 0x10 loads `bus_wdata[6:0]` into the mask; `bus_wdata[7]` is discarded. The mask cannot be read back, because a read at 0x10 always returns status.
- R2: Status and mask bit 0 belong to `alarm_hit`. Bits 1 to 6 belong to `tick_strobe[0]` to `tick_strobe[5]`, which are 100 Hz, 10 Hz, second, minute, hour and day.
- R3: When a source strobe is high on a clock edge and its mask bit is 1, its status flag is 1 from that edge onward.
- R4: When a mask bit is 0, a strobe on that source never sets its flag.
- R5: A set flag stays set until a status read, no matter how many cycles pass.
- R6: A read with `bus_addr` = 0x10 returns {global, flags[6:0]} combinationally in the same cycle. On the closing edge of that cycle all flags and the global bit clear.
- R7: An enabled source strobe that arrives in the same cycle as a status read is not lost: its flag is set after the clearing edge.
- R8: Status bit 7 is 1 exactly when at least one flag is set. `irq_n` is 0 while that bit is 1 and 1 otherwise.
- R9: An alarm strobe and periodic strobes in the same cycle set all of their enabled flags together.
- R10: Reads at any address other than 0x10 (including 0x12 to 0x1F) return 0x00 and do not clear flags. Writes there leave the mask unchanged.
- R11: After reset the mask is 0x00, all flags are 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm_hit | input | 1 | One-cycle alarm-match strobe |
| tick_strobe | input | 6 | Periodic strobes: 100 Hz, 10 Hz, s, min, h, day |
| bus_addr | input | 5 | Register address |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach from the ports is an enabled strobe that lands in the same cycle as a status read, because the clear and the new event meet on one edge. The bench drives the strobe and the read strobe on the same falling edge. It expects 0x00 on that read, then a low `irq_n` and the new flag on the next read. Reads at unused addresses are issued while flags are pending, which shows that those reads do not clear the flags.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int RTC_ADDR_W  = 5;
  localparam int RTC_TICK_N  = 6;
  localparam logic [RTC_ADDR_W-1:0] RTC_STAT_ADDR = 5'h10;
endpackage

// File: rtl/irq_bus_port.sv
module irq_bus_port #(
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              hit_wr,
  output logic              hit_rd
);
  logic sel;
  assign sel    = (addr == STAT_ADDR);
  assign hit_wr = wr & sel;
  assign hit_rd = rd & sel;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int SRC_N = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SRC_N-1:0] din,
  output logic [SRC_N-1:0] mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask <= '0;
    else if (load)  mask <= din;
  end

  // R1: a write to the shared address lands in the mask
  p_mask_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> mask == $past(din));
  // R10: without a load the mask holds
  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mask));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int SRC_N = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] src,
  input  logic [SRC_N-1:0] mask,
  input  logic             clr,
  output logic [SRC_N-1:0] flags,
  output logic             gflag
);
  function automatic logic merge(input logic cur, input logic ev, input logic wipe);
    return wipe ? ev : (cur | ev);
  endfunction

  logic [SRC_N-1:0] ev;
  logic             any_ev;
  assign ev     = src & mask;
  assign any_ev = |ev;

  for (genvar i = 0; i < SRC_N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= merge(flags[i], ev[i], clr);
    end

    // R4: a disabled source leaves a clear flag clear
    p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!mask[i] && !flags[i]) |=> !flags[i]);
    // R5: a set flag persists until a status read
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !clr) |=> flags[i]);
    // R3: an enabled strobe sets its flag
    p_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (src[i] && mask[i]) |=> flags[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gflag <= 1'b0;
    else        gflag <= merge(gflag, any_ev, clr);
  end

  // R8: global bit mirrors the OR of the flags
  p_global_or_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gflag == (|flags));
  // R6: a read with no new event empties the bank
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !any_ev) |=> (flags == '0) && !gflag);
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit #(
  parameter int ADDR_W = rtc_irq_pkg::RTC_ADDR_W,
  parameter int TICK_N = rtc_irq_pkg::RTC_TICK_N,
  parameter logic [ADDR_W-1:0] STAT_ADDR = rtc_irq_pkg::RTC_STAT_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alarm_hit,
  input  logic [TICK_N-1:0] tick_strobe,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [TICK_N+1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [TICK_N+1:0] bus_rdata,
  output logic              irq_n
);
  localparam int SRC_N  = TICK_N + 1;
  localparam int DATA_W = SRC_N + 1;

  function automatic logic [DATA_W-1:0] status_word(input logic g, input logic [SRC_N-1:0] f);
    return {g, f};
  endfunction

  logic             stat_wr, stat_rd;
  logic [SRC_N-1:0] mask, flags, src_vec;
  logic             gflag;
  logic             unused_wbit;

  assign unused_wbit = bus_wdata[DATA_W-1];
  assign src_vec     = {tick_strobe, alarm_hit};

  irq_bus_port #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_port (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .hit_wr(stat_wr), .hit_rd(stat_rd)
  );

  irq_mask_reg #(.SRC_N(SRC_N)) u_mask (
    .clk(clk), .rst_n(rst_n), .load(stat_wr),
    .din(bus_wdata[SRC_N-1:0]), .mask(mask)
  );

  irq_flag_bank #(.SRC_N(SRC_N)) u_flags (
    .clk(clk), .rst_n(rst_n), .src(src_vec), .mask(mask),
    .clr(stat_rd), .flags(flags), .gflag(gflag)
  );

  assign bus_rdata = stat_rd ? status_word(gflag, flags) : '0;
  assign irq_n     = ~gflag;

  // R10: reads away from the status address return zero
  p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr != STAT_ADDR) |-> bus_rdata == '0);
  // R10: such reads leave pending flags in place
  p_unused_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rd && gflag) |=> gflag);
  // R8: interrupt line follows the global bit
  p_irq_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gflag) |-> !irq_n);
endmodule

// File: tb/tb_rtc_irq_unit.sv
module tb_rtc_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alarm_hit = 1'b0;
  logic [5:0] tick_strobe = '0;
  logic [4:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq_n;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  rtc_irq_unit dut (
    .clk(clk), .rst_n(rst_n), .alarm_hit(alarm_hit), .tick_strobe(tick_strobe),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  // monitor: pops expected read data while a read is on the bus
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (bus_rd) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL scoreboard empty: actual=%02h expected=none", bus_rdata);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (bus_rdata !== e) begin
            bad++;
            $display("FAIL %s: rdata actual=%02h expected=%02h", t, bus_rdata, e);
          end
        end
      end
    end
  end

  task automatic step(input logic al, input logic [5:0] tk, input logic rd,
                      input logic wr, input logic [4:0] a, input logic [7:0] wd,
                      input logic [7:0] e, input string t);
    @(negedge clk);
    alarm_hit = al; tick_strobe = tk; bus_rd = rd; bus_wr = wr;
    bus_addr = a; bus_wdata = wd;
    if (rd) begin exp_q.push_back(e); tag_q.push_back(t); end
  endtask

  task automatic idle();
    step(1'b0, 6'h0, 1'b0, 1'b0, 5'h0, 8'h0, 8'h0, "");
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [7:0] e, input string t);
    step(1'b0, 6'h0, 1'b1, 1'b0, a, 8'h0, e, t);
    idle();
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    step(1'b0, 6'h0, 1'b0, 1'b1, a, d, 8'h0, "");
    idle();
  endtask

  task automatic strobe(input logic al, input logic [5:0] tk);
    step(al, tk, 1'b0, 1'b0, 5'h0, 8'h0, 8'h0, "");
    idle();
  endtask

  task automatic chk_irq(input logic e, input string t);
    #2;
    total++;
    if (irq_n !== e) begin
      bad++;
      $display("FAIL %s: irq_n actual=%0b expected=%0b", t, irq_n, e);
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_irq(1'b1, "R11 irq_n in reset");
    rst_n = 1'b1;
    idle();
    chk_irq(1'b1, "R11 irq_n after reset");
    rd_chk(5'h10, 8'h00, "R11 status after reset");

    // R4: mask zero, every source fires
    strobe(1'b1, 6'h3F);
    chk_irq(1'b1, "R4 masked sources keep irq high");
    rd_chk(5'h10, 8'h00, "R4 masked sources set nothing");

    // R1: enable all, bit 7 of write discarded
    wr_reg(5'h10, 8'hFF);
    strobe(1'b1, 6'h00);
    chk_irq(1'b0, "R8 irq low with alarm flag");
    rd_chk(5'h10, 8'h81, "R1 R2 R3 alarm flag on bit 0");
    chk_irq(1'b1, "R6 irq high after read");
    rd_chk(5'h10, 8'h00, "R6 flags cleared by read");

    // R2: each periodic strobe on its own bit
    for (int i = 0; i < 6; i++) begin
      strobe(1'b0, 6'(1 << i));
      rd_chk(5'h10, 8'h80 | 8'(1 << (i + 1)), "R2 periodic bit position");
    end

    // R9: alarm with second strobe together
    strobe(1'b1, 6'h04);
    rd_chk(5'h10, 8'h89, "R9 alarm and second together");

    // R5: sticky over idle cycles
    strobe(1'b0, 6'h01);
    repeat (6) idle();
    chk_irq(1'b0, "R5 irq held while pending");
    rd_chk(5'h10, 8'h82, "R5 100 Hz flag held");

    // R7: day strobe in the same cycle as a status read
    step(1'b0, 6'h20, 1'b1, 1'b0, 5'h10, 8'h00, 8'h00, "R7 read sees pre-event state");
    idle();
    chk_irq(1'b0, "R7 event kept through clear");
    rd_chk(5'h10, 8'hC0, "R7 day flag pending");

    // R10: unused-address writes and reads
    wr_reg(5'h15, 8'h00);
    wr_reg(5'h1F, 8'h00);
    strobe(1'b1, 6'h00);
    rd_chk(5'h12, 8'h00, "R10 read 0x12 is zero");
    rd_chk(5'h1F, 8'h00, "R10 read 0x1F is zero");
    chk_irq(1'b0, "R10 unused read keeps flags");
    rd_chk(5'h10, 8'h81, "R10 mask unchanged and flag kept");

    // R1: partial mask enables only 10 Hz
    wr_reg(5'h10, 8'h04);
    strobe(1'b1, 6'h3F);
    rd_chk(5'h10, 8'h84, "R1 partial mask");
    strobe(1'b1, 6'h3D);
    chk_irq(1'b1, "R4 disabled sources quiet");
    rd_chk(5'h10, 8'h00, "R4 disabled sources set nothing");

    repeat (2) idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule